// File: doc/BRIEF.md
# Speed Mode and Tune Control Register

This block is the speed-selection and sampling-tune control register of an SD/eMMC host controller. Software reads and writes one 16-bit word. The word holds a 3-bit bus speed mode and a 6-bit receive sampling tune value. It also has a self-clearing apply bit. The receive sampling delay that goes to the delay line is not a direct copy of the tune field. It is loaded only when software sets the apply bit. The block clears the apply bit by itself and raises a one-cycle completion pulse at the same time.

The register also decodes the mode for the downstream datapath. This decode is a one-hot speed selection plus a flag for double-data-rate sampling. A separate enhanced-strobe control input moves the mode between plain HS400 and HS400 with enhanced strobe, and changes nothing else. Software updates the register with read-modify-write, so every write carries the full word back. The mode field and the tune field are stored independently of each other.

Top module: `emmc_speed_tune_reg`

## Requirements
- R1: After reset, readback is 0 (mode 0, tune 0, apply bit 0). The applied delay is 0, the done pulse is low, the speed selection shows SD, and the DDR flag is low.
- R2: A write stores word bits 2:0 as the mode and bits 13:8 as the tune value. Readback shows the mode in bits 2:0, the tune in bits 13:8 and the apply bit in bit 15. All other bits read 0.
- R3: A write with bit 15 clear leaves the applied delay output unchanged, whatever tune value it stores.
- R4: A write with bit 15 set, while the block is idle, makes bit 15 read 1 for the two cycles after the write edge. Bit 15 clears on the second edge after the write. On that same edge, the done output goes high for exactly one cycle.
- R5: On the edge where the apply bit clears, the applied delay output takes the tune field value stored at that moment when it is 42 or less. When the stored value is 43 or more, the applied delay takes 0.
- R6: While an update is in progress, writing bit 15 as 1 does not restart the update. Writing bit 15 as 0 does not cancel it. Mode and tune writes still take effect.
- R7: The speed selection output is one-hot, with bit 0 SD, bit 1 MMC SDR, bit 2 MMC DDR, bit 3 HS200, bit 4 HS400 and bit 5 HS400 enhanced strobe. The mode codes are 0 SD, 2 SDR, 3 DDR, 4 HS200, 5 HS400 and 6 HS400 enhanced strobe. Codes 1 and 7 select SD.
- R8: The DDR flag is high exactly when the mode is 3, 5 or 6.
- R9: An enhanced-strobe request with value 1 changes mode 5 to 6. A request with value 0 changes mode 6 to 5. In every other mode the request leaves the mode unchanged. The tune and apply fields never change. A register write on the same cycle takes precedence and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Full register word to write |
| es_req | input | 1 | Enhanced-strobe change request |
| es_val | input | 1 | Requested enhanced-strobe state |
| rd_data | output | 16 | Register readback |
| tune_dly | output | 6 | Applied receive sampling delay |
| tune_done | output | 1 | One-cycle pulse when an update completes |
| speed_sel | output | 6 | One-hot decoded speed mode |
| ddr_mode | output | 1 | High for double-data-rate modes |

## Verification
The bench builds the block with its default 6-bit tune field and a limit of 42. This places the last valid value and the first wrapping values (43 and 63) within reach of a single write. All eight mode codes are swept, including the two reserved codes. Apply writes are issued during an update, and on the very edge the update completes, to cover restart and cancel attempts. Enhanced-strobe requests are sent in modes 4, 5 and 6 and together with a write.

// File: rtl/emmc_speed_tune_reg.sv
module emmc_speed_tune_reg #(
  parameter int TUNE_W    = 6,
  parameter int TUNE_LAST = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic              es_req,
  input  logic              es_val,
  output logic [15:0]       rd_data,
  output logic [TUNE_W-1:0] tune_dly,
  output logic              tune_done,
  output logic [5:0]        speed_sel,
  output logic              ddr_mode
);
  localparam int TUNE_LO = 8;
  localparam int APPLY_BIT = 15;
  localparam logic [2:0] M_SD = 3'd0, M_SDR = 3'd2, M_DDR = 3'd3,
                         M_HS200 = 3'd4, M_HS400 = 3'd5, M_HS400ES = 3'd6;

  logic [2:0]        mode_q;
  logic [TUNE_W-1:0] tune_q;
  logic              apply_q;
  logic              stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_SD;
      tune_q    <= '0;
      apply_q   <= 1'b0;
      stage_q   <= 1'b0;
      tune_dly  <= '0;
      tune_done <= 1'b0;
    end else begin
      tune_done <= 1'b0;
      if (apply_q) begin
        if (stage_q) begin
          apply_q   <= 1'b0;
          stage_q   <= 1'b0;
          tune_done <= 1'b1;
          tune_dly  <= (int'(tune_q) > TUNE_LAST) ? '0 : tune_q;
        end else begin
          stage_q <= 1'b1;
        end
      end else if (wr_en && wr_data[APPLY_BIT]) begin
        apply_q <= 1'b1;
        stage_q <= 1'b0;
      end
      if (wr_en) begin
        mode_q <= wr_data[2:0];
        tune_q <= wr_data[TUNE_LO +: TUNE_W];
      end else if (es_req) begin
        if (mode_q == M_HS400 && es_val)    mode_q <= M_HS400ES;
        if (mode_q == M_HS400ES && !es_val) mode_q <= M_HS400;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[2:0] = mode_q;
    rd_data[TUNE_LO +: TUNE_W] = tune_q;
    rd_data[APPLY_BIT] = apply_q;
  end

  always_comb begin
    case (mode_q)
      M_SDR:     speed_sel = 6'b000010;
      M_DDR:     speed_sel = 6'b000100;
      M_HS200:   speed_sel = 6'b001000;
      M_HS400:   speed_sel = 6'b010000;
      M_HS400ES: speed_sel = 6'b100000;
      default:   speed_sel = 6'b000001;
    endcase
  end

  assign ddr_mode = (mode_q == M_DDR) || (mode_q == M_HS400) || (mode_q == M_HS400ES);

  p_apply_two_cycles_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(apply_q) |=> apply_q ##1 !apply_q);
  p_done_on_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(apply_q) |-> tune_done);
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tune_done |=> !tune_done);
  p_dly_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tune_done |-> $stable(tune_dly));
  p_dly_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tune_dly) <= TUNE_LAST);
  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(speed_sel) == 1);
  p_ddr_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_mode |-> (speed_sel[2] || speed_sel[4] || speed_sel[5]));
endmodule

// File: tb/emmc_speed_tune_reg_bench.sv
module emmc_speed_tune_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic es_req = 1'b0;
  logic es_val = 1'b0;
  logic [15:0] rd_data;
  logic [5:0]  tune_dly;
  logic        tune_done;
  logic [5:0]  speed_sel;
  logic        ddr_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int m_mode = 0, m_tune = 0, m_apply = 0, m_cnt = 0, m_dly = 0, m_done = 0;

  always #10 clk = ~clk;

  emmc_speed_tune_reg u_emmc_speed_tune_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .es_req(es_req), .es_val(es_val), .rd_data(rd_data), .tune_dly(tune_dly),
    .tune_done(tune_done), .speed_sel(speed_sel), .ddr_mode(ddr_mode));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_sel(input int m);
    case (m)
      2: return 2;
      3: return 4;
      4: return 8;
      5: return 16;
      6: return 32;
      default: return 1;
    endcase
  endfunction

  task automatic compare_all();
    int exp_rd;
    exp_rd = (m_apply << 15) | (m_tune << 8) | m_mode;
    chk(int'(rd_data) == exp_rd, "R2 readback", int'(rd_data), exp_rd);
    chk(int'(tune_dly) == m_dly, "R5 applied delay", int'(tune_dly), m_dly);
    chk(int'(tune_done) == m_done, "R4 done pulse", int'(tune_done), m_done);
    chk(int'(speed_sel) == exp_sel(m_mode), "R7 speed select", int'(speed_sel), exp_sel(m_mode));
    chk(int'(ddr_mode) == int'(m_mode == 3 || m_mode == 5 || m_mode == 6),
        "R8 ddr flag", int'(ddr_mode), int'(m_mode == 3 || m_mode == 5 || m_mode == 6));
  endtask

  task automatic step(input bit w, input logic [15:0] d, input bit e, input bit ev);
    int busy;
    wr_en = w; wr_data = d; es_req = e; es_val = ev;
    @(posedge clk);
    busy = m_apply;
    m_done = 0;
    if (m_apply != 0) begin
      if (m_cnt == 1) begin
        m_apply = 0;
        m_done = 1;
        m_dly = (m_tune > 42) ? 0 : m_tune;
      end else m_cnt++;
    end
    if (w) begin
      m_mode = int'(d[2:0]);
      m_tune = int'(d[13:8]);
      if (d[15] && busy == 0) begin m_apply = 1; m_cnt = 0; end
    end else if (e) begin
      if (m_mode == 5 && ev) m_mode = 6;
      else if (m_mode == 6 && !ev) m_mode = 5;
    end
    @(negedge clk);
    wr_en = 0; es_req = 0;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 16'h0, 0, 0);
  endtask

  function automatic logic [15:0] word(input int apply, input int tune, input int mode);
    return 16'((apply << 15) | (tune << 8) | mode);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == 16'h0, "R1 readback", int'(rd_data), 0);
    chk(tune_dly == 6'd0 && !tune_done, "R1 delay/done", int'(tune_dly), 0);
    chk(speed_sel == 6'b1 && !ddr_mode, "R1 decode", int'(speed_sel), 1);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R7 R8 sweep of all mode codes, including reserved 1 and 7
    for (int m = 0; m < 8; m++) step(1, word(0, m + 3, m), 0, 0);

    // R3 tune write without apply keeps delay
    step(1, word(0, 20, 4), 0, 0);
    chk(tune_dly == 6'd0, "R3 delay unchanged", int'(tune_dly), 0);
    idle(2);

    // R4 R5 apply with tune 20
    step(1, word(1, 20, 4), 0, 0);
    chk(rd_data[15] == 1'b1, "R4 apply set", int'(rd_data[15]), 1);
    idle(3);
    chk(tune_dly == 6'd20, "R5 delay 20", int'(tune_dly), 20);

    // R5 boundary values
    step(1, word(1, 42, 2), 0, 0); idle(3);
    chk(tune_dly == 6'd42, "R5 delay 42", int'(tune_dly), 42);
    step(1, word(1, 43, 2), 0, 0); idle(3);
    chk(tune_dly == 6'd0, "R5 wrap 43", int'(tune_dly), 0);
    step(1, word(0, 7, 2), 0, 0);
    step(1, word(1, 7, 2), 0, 0); idle(3);
    step(1, word(1, 63, 2), 0, 0); idle(3);
    chk(tune_dly == 6'd0, "R5 wrap 63", int'(tune_dly), 0);

    // R6 writes during update: cancel attempt, restart attempt, edge of completion
    step(1, word(1, 10, 4), 0, 0);
    step(1, word(0, 11, 4), 0, 0);
    chk(rd_data[15] == 1'b1, "R6 no cancel", int'(rd_data[15]), 1);
    step(1, word(1, 12, 4), 0, 0);
    chk(rd_data[15] == 1'b0 && tune_done, "R6 no restart", int'(rd_data[15]), 0);
    idle(3);
    chk(tune_dly == 6'd11, "R6 delay from stored tune", int'(tune_dly), 11);
    step(1, word(1, 30, 4), 0, 0);
    step(1, word(1, 31, 4), 0, 0);
    step(1, word(1, 32, 4), 0, 0);
    idle(3);

    // R9 enhanced strobe handling
    step(1, word(0, 5, 5), 0, 0);
    step(0, 16'h0, 1, 1);
    chk(rd_data[2:0] == 3'd6, "R9 5->6", int'(rd_data[2:0]), 6);
    step(0, 16'h0, 1, 1);
    step(0, 16'h0, 1, 0);
    chk(rd_data[2:0] == 3'd5 && rd_data[13:8] == 6'd5, "R9 6->5", int'(rd_data), 16'h0505);
    step(0, 16'h0, 1, 0);
    step(1, word(0, 9, 4), 0, 0);
    step(0, 16'h0, 1, 1);
    chk(rd_data[2:0] == 3'd4, "R9 HS200 unchanged", int'(rd_data[2:0]), 4);
    step(1, word(0, 9, 5), 0, 0);
    step(1, word(0, 9, 5), 1, 1);
    chk(rd_data[2:0] == 3'd5, "R9 write wins", int'(rd_data[2:0]), 5);
    step(1, word(1, 9, 5), 0, 0);
    step(0, 16'h0, 1, 1);
    idle(3);
    chk(tune_dly == 6'd9, "R9 tune untouched", int'(tune_dly), 9);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule